// File: doc/BRIEF.md
# GPIO Port Direction and Data Register File

This block is the register file behind a general-purpose I/O port of up to 50 pins. Software reaches it over a simple 16-bit register bus (write strobe, read strobe, 9-bit byte offset). The block holds a direction bit and an output value for every pin and returns pin levels on read-back. For the lowest fifteen pins it also holds pull resistor controls. Toward the pad ring it drives, per pin, an output value and an output enable, plus pull enable and pull polarity for the low pins. It receives the raw pad levels, which pass through a synchroniser before software can see them.

A parameter selects one of three build variants: a 50-pin port with pull control, a 36-pin port, or a 48-pin port. The variant decides which pins exist and how pins 32 and above are controlled. In the 50- and 36-pin variants, offset 0x1C holds output values for pins 32–47, and those pins always stay inputs. In the 50-pin variant, offset 0x1E holds values for pins 48/49 in bits 0/1 and their enables in bits 8/9. In the 48-pin variant, offset 0x1C is a full output-enable register for pins 32–47 (bit = pin−32), and 0x1E carries their output values at the same bit positions. Bits belonging to pins the variant lacks read as zero and cannot be written.

Top module: `gpio_portregs`

## Requirements
- R1: After synchronous reset every register is zero: pad_oe, pad_out, pad_pull_en and pad_pull_up are all zero and every register reads zero while pads are low.
- R2: Offsets 0x000 (pins 0–15) and 0x002 (pins 16–31) hold direction, bit n−base; 1 = output, 0 = input. pad_oe follows a write on the clock edge that samples the strobe.
- R3: Offsets 0x004 (pins 0–15) and 0x006 (pins 16–31) hold output values; pad_out follows a write on the edge that samples the strobe.
- R4: A data read returns, per bit, the stored value for an output pin and the synchronised pad level (two flops) for an input pin.
- R5: In the 50-pin variant, pins 32–47 are never outputs and a read of 0x01C returns their pad levels. Pins 48/49 use 0x01E: value in bits 0/1, enable in bits 8/9. The read returns the enables plus per-R4 read-back in bits 0/1.
- R6: In the 48-pin variant, 0x01C is the output enable of pins 32–47 (bit pin−32) and reads back as stored. 0x01E holds their values and reads back per R4.
- R7: In the 50-pin variant, 0x1E0 is pull enable (1 = on) and 0x1E2 is pull direction (1 = up, 0 = down) for pins 0–14 only. Bit 15 reads zero, and both drive pad_pull_en / pad_pull_up the cycle after the write.
- R8: In the 36- and 48-pin variants, the pull registers read zero and ignore writes. In the 36-pin variant, 0x01E reads zero, 0x01C returns only pins 32–35, and no pin above 31 drives.
- R9: Reads of unmapped offsets return zero, and writes to them change no pad output and no register.
- R10: bus_rdata is registered: it updates the cycle after a read strobe and holds its value while no read is strobed.
- R11: A read and a write to the same offset in one cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 50 | Raw pad input levels |
| pad_oe | output | 50 | Per-pin output enable |
| pad_out | output | 50 | Per-pin output value |
| pad_pull_en | output | 15 | Pull enable, pins 0–14 |
| pad_pull_up | output | 15 | Pull polarity, 1 = up, pins 0–14 |

## Verification
A corrupted direction or value bit shows up directly on pad_oe or pad_out. It appears in the cycle after the write that should have set it, since the pads are wired straight from the storage flops. A wrong variant mask shows either as a pin above the pin count that drives, or as a pull bit that latches when it should not. Both appear at once on the pad ports and again on the next read. A broken synchroniser or read mux shows in read data taken three cycles after a pad change, where input bits must track pad_in and output bits must keep the stored value.

// File: rtl/gpio_portregs_pkg.sv
package gpio_portregs_pkg;

  typedef enum logic [1:0] {
    GV_PULL50 = 2'd0,
    GV_PIN36  = 2'd1,
    GV_PIN48  = 2'd2
  } gpio_variant_e;

  localparam int REG_AW    = 9;
  localparam int REG_DW    = 16;
  localparam int MAX_PINS  = 50;
  localparam int PULL_PINS = 15;
  localparam int NUM_REGS  = 8;

  // register slot indices
  localparam int RI_DIR_LO = 0;
  localparam int RI_DIR_HI = 1;
  localparam int RI_VAL_LO = 2;
  localparam int RI_VAL_HI = 3;
  localparam int RI_EXT_A  = 4;
  localparam int RI_EXT_B  = 5;
  localparam int RI_PULLEN = 6;
  localparam int RI_PULLUP = 7;

  function automatic int pin_count(gpio_variant_e v);
    case (v)
      GV_PULL50: return 50;
      GV_PIN36:  return 36;
      default:   return 48;
    endcase
  endfunction

  function automatic logic [REG_AW-1:0] reg_offset(int idx);
    case (idx)
      RI_DIR_LO: return 9'h000;
      RI_DIR_HI: return 9'h002;
      RI_VAL_LO: return 9'h004;
      RI_VAL_HI: return 9'h006;
      RI_EXT_A:  return 9'h01C;
      RI_EXT_B:  return 9'h01E;
      RI_PULLEN: return 9'h1E0;
      default:   return 9'h1E2;
    endcase
  endfunction

  // bits of pins 32..47 that exist in a variant
  function automatic logic [REG_DW-1:0] ext_pin_mask(gpio_variant_e v);
    int n;
    n = pin_count(v) - 32;
    if (n >= 16) return '1;
    return REG_DW'((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [REG_DW-1:0] reg_wmask(gpio_variant_e v, int idx);
    case (idx)
      RI_EXT_A: return ext_pin_mask(v);
      RI_EXT_B: begin
        if (v == GV_PIN48)  return ext_pin_mask(v);
        if (v == GV_PULL50) return 16'h0303;
        return '0;
      end
      RI_PULLEN, RI_PULLUP:
        return (v == GV_PULL50) ? REG_DW'((32'd1 << PULL_PINS) - 32'd1) : '0;
      default: return '1;
    endcase
  endfunction

  function automatic logic is_mapped(logic [REG_AW-1:0] a);
    for (int i = 0; i < NUM_REGS; i++)
      if (a == reg_offset(i)) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/gpio_csr16.sv
module gpio_csr16 #(
  parameter int AW = 9,
  parameter int DW = 16,
  parameter logic [AW-1:0] ADDR  = '0,
  parameter logic [DW-1:0] WMASK = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (wr_en && addr == ADDR)
      q <= wdata & WMASK;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 50,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++)
        stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_map.sv
module gpio_pin_map
  import gpio_portregs_pkg::*;
#(
  parameter gpio_variant_e VARIANT = GV_PULL50
) (
  input  logic [NUM_REGS-1:0][REG_DW-1:0] regs,
  output logic [MAX_PINS-1:0]             oe_v,
  output logic [MAX_PINS-1:0]             val_v
);

  localparam int NPINS = pin_count(VARIANT);
  localparam logic [MAX_PINS-1:0] PIN_EXIST = MAX_PINS'((64'd1 << NPINS) - 64'd1);

  logic [MAX_PINS-1:0] oe_raw, val_raw;

  always_comb begin
    oe_raw  = '0;
    val_raw = '0;
    oe_raw[15:0]   = regs[RI_DIR_LO];
    oe_raw[31:16]  = regs[RI_DIR_HI];
    val_raw[15:0]  = regs[RI_VAL_LO];
    val_raw[31:16] = regs[RI_VAL_HI];
    if (VARIANT == GV_PIN48) begin
      oe_raw[47:32]  = regs[RI_EXT_A];
      val_raw[47:32] = regs[RI_EXT_B];
    end else begin
      val_raw[47:32] = regs[RI_EXT_A];
      if (VARIANT == GV_PULL50) begin
        val_raw[49:48] = regs[RI_EXT_B][1:0];
        oe_raw[49:48]  = regs[RI_EXT_B][9:8];
      end
    end
  end

  assign oe_v  = oe_raw & PIN_EXIST;
  assign val_v = val_raw & PIN_EXIST;

endmodule

// File: rtl/gpio_portregs.sv
module gpio_portregs
  import gpio_portregs_pkg::*;
#(
  parameter gpio_variant_e VARIANT     = GV_PULL50,
  parameter int            SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [REG_AW-1:0]    bus_addr,
  input  logic [REG_DW-1:0]    bus_wdata,
  output logic [REG_DW-1:0]    bus_rdata,
  input  logic [MAX_PINS-1:0]  pad_in,
  output logic [MAX_PINS-1:0]  pad_oe,
  output logic [MAX_PINS-1:0]  pad_out,
  output logic [PULL_PINS-1:0] pad_pull_en,
  output logic [PULL_PINS-1:0] pad_pull_up
);

  localparam int NPINS = pin_count(VARIANT);
  localparam logic [MAX_PINS-1:0] PIN_EXIST = MAX_PINS'((64'd1 << NPINS) - 64'd1);
  localparam logic [REG_AW-1:0] OFS_DIR_LO = reg_offset(RI_DIR_LO);
  localparam logic [REG_AW-1:0] OFS_DIR_HI = reg_offset(RI_DIR_HI);
  localparam logic [REG_AW-1:0] OFS_VAL_LO = reg_offset(RI_VAL_LO);
  localparam logic [REG_AW-1:0] OFS_VAL_HI = reg_offset(RI_VAL_HI);
  localparam logic [REG_AW-1:0] OFS_EXT_A  = reg_offset(RI_EXT_A);
  localparam logic [REG_AW-1:0] OFS_EXT_B  = reg_offset(RI_EXT_B);
  localparam logic [REG_AW-1:0] OFS_PULLEN = reg_offset(RI_PULLEN);
  localparam logic [REG_AW-1:0] OFS_PULLUP = reg_offset(RI_PULLUP);

  logic [NUM_REGS-1:0][REG_DW-1:0] rq;
  logic [MAX_PINS-1:0] pin_lvl, oe_v, val_v, rb_v;
  logic [REG_DW-1:0]   rd_next;

  // storage: one masked register per mapped offset
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    gpio_csr16 #(
      .AW   (REG_AW),
      .DW   (REG_DW),
      .ADDR (reg_offset(g)),
      .WMASK(reg_wmask(VARIANT, g))
    ) u_reg (
      .clk  (clk),
      .rst  (rst),
      .wr_en(bus_wr),
      .addr (bus_addr),
      .wdata(bus_wdata),
      .q    (rq[g])
    );
  end

  gpio_in_sync #(
    .WIDTH (MAX_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pad_in & PIN_EXIST),
    .dout(pin_lvl)
  );

  gpio_pin_map #(
    .VARIANT(VARIANT)
  ) u_map (
    .regs (rq),
    .oe_v (oe_v),
    .val_v(val_v)
  );

  // per-pin read-back: stored value when driving, pad level otherwise
  assign rb_v = (oe_v & val_v) | (~oe_v & pin_lvl);

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      OFS_DIR_LO: rd_next = rq[RI_DIR_LO];
      OFS_DIR_HI: rd_next = rq[RI_DIR_HI];
      OFS_VAL_LO: rd_next = rb_v[15:0];
      OFS_VAL_HI: rd_next = rb_v[31:16];
      OFS_EXT_A:  rd_next = (VARIANT == GV_PIN48) ? rq[RI_EXT_A] : rb_v[47:32];
      OFS_EXT_B: begin
        if (VARIANT == GV_PIN48)
          rd_next = rb_v[47:32];
        else if (VARIANT == GV_PULL50)
          rd_next = (rq[RI_EXT_B] & 16'h0300) | {14'b0, rb_v[49:48]};
        else
          rd_next = rq[RI_EXT_B];
      end
      OFS_PULLEN: rd_next = rq[RI_PULLEN];
      OFS_PULLUP: rd_next = rq[RI_PULLUP];
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_next;
  end

  assign pad_oe      = oe_v;
  assign pad_out     = val_v;
  assign pad_pull_en = rq[RI_PULLEN][PULL_PINS-1:0];
  assign pad_pull_up = rq[RI_PULLUP][PULL_PINS-1:0];

  // R2
  dir_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_DIR_LO) |=> (pad_oe[15:0] == $past(bus_wdata)));

  // R3
  val_lo_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_VAL_LO) |=> (pad_out[15:0] == $past(bus_wdata)));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !is_mapped(bus_addr)) |=>
      ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pull_en) && $stable(pad_pull_up)));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !is_mapped(bus_addr)) |=> (bus_rdata == '0));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R11
  dir_hi_read_old_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == OFS_DIR_HI) |=> (bus_rdata == $past(pad_oe[31:16])));

endmodule

// File: tb/test_gpio_portregs.sv
module test_gpio_portregs;
  import gpio_portregs_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [49:0] pad_in = '0;

  logic [15:0] rd_a, rd_b, rd_c;
  logic [49:0] oe_a, oe_b, oe_c, out_a, out_b, out_c;
  logic [14:0] pen_a, pen_b, pen_c, pup_a, pup_b, pup_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_portregs #(.VARIANT(GV_PULL50)) i_gpio_portregs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_a), .pad_in(pad_in), .pad_oe(oe_a),
    .pad_out(out_a), .pad_pull_en(pen_a), .pad_pull_up(pup_a));

  gpio_portregs #(.VARIANT(GV_PIN36)) i_gpio_portregs_v36 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pad_in(pad_in), .pad_oe(oe_b),
    .pad_out(out_b), .pad_pull_en(pen_b), .pad_pull_up(pup_b));

  gpio_portregs #(.VARIANT(GV_PIN48)) i_gpio_portregs_v48 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_c), .pad_in(pad_in), .pad_oe(oe_c),
    .pad_out(out_c), .pad_pull_en(pen_c), .pad_pull_up(pup_c));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    check("R1 pad_oe after reset", 64'(oe_a), 64'd0);
    check("R1 pad_out after reset", 64'(out_a), 64'd0);
    check("R1 pull outputs after reset", 64'({pen_a, pup_a}), 64'd0);
    bus_read(9'h000);
    check("R1 direction reads zero", 64'(rd_a), 64'd0);
    bus_read(9'h004);
    check("R1 data reads zero", 64'(rd_a), 64'd0);
  endtask

  task automatic test_direction();
    bus_write(9'h000, 16'hA5A5);
    check("R2 pad_oe low half", 64'(oe_a[15:0]), 64'hA5A5);
    bus_write(9'h002, 16'h1234);
    check("R2 pad_oe high half", 64'(oe_a[31:16]), 64'h1234);
    bus_read(9'h002);
    check("R2 direction read-back", 64'(rd_a), 64'h1234);
  endtask

  task automatic test_data();
    bus_write(9'h004, 16'hFFFF);
    bus_write(9'h006, 16'h00FF);
    check("R3 pad_out pins 0-31", 64'(out_a[31:0]), 64'h00FF_FFFF);
  endtask

  task automatic test_readback();
    pad_in[31:0] = 32'h0F0F_3C3C;
    settle();
    bus_read(9'h004);
    check("R4 mixed read pins 0-15", 64'(rd_a),
          64'((16'hA5A5 & 16'hFFFF) | (~16'hA5A5 & 16'h3C3C)));
    bus_read(9'h006);
    check("R4 mixed read pins 16-31", 64'(rd_a),
          64'((16'h1234 & 16'h00FF) | (~16'h1234 & 16'h0F0F)));
  endtask

  task automatic test_upper_pins();
    pad_in[47:32] = 16'hC3C3;
    pad_in[49:48] = 2'b10;
    settle();
    bus_write(9'h01C, 16'hFFFF);
    bus_write(9'h01E, 16'h0101);
    check("R5 pins 32-47 stay inputs (50-pin)", 64'(oe_a[47:32]), 64'd0);
    check("R5 pins 48/49 enables", 64'(oe_a[49:48]), 64'b01);
    check("R5 pins 48/49 values", 64'(out_a[49:48]), 64'b01);
    check("R8 no upper pin drives (36-pin)", 64'(oe_b[49:32]), 64'd0);
    check("R6 pins 32-47 enables (48-pin)", 64'(oe_c[47:32]), 64'hFFFF);
    check("R6 pins 32-47 values (48-pin)", 64'(out_c[47:32]), 64'h0101);
    check("R6 no pins 48/49 (48-pin)", 64'(oe_c[49:48]), 64'd0);
    bus_read(9'h01C);
    check("R5 0x1C reads pad levels", 64'(rd_a), 64'hC3C3);
    check("R8 0x1C only pins 32-35 (36-pin)", 64'(rd_b), 64'h0003);
    check("R6 0x1C reads enables", 64'(rd_c), 64'hFFFF);
    bus_read(9'h01E);
    check("R5 0x1E enables and read-back", 64'(rd_a), 64'h0103);
    check("R8 0x1E reads zero (36-pin)", 64'(rd_b), 64'd0);
    check("R6 0x1E driven values", 64'(rd_c), 64'h0101);
    bus_write(9'h01C, 16'h00FF);
    bus_read(9'h01E);
    check("R6 0x1E mixed read-back", 64'(rd_c), 64'hC301);
    bus_read(9'h01C);
    check("R5 0x1C unaffected by write (50-pin)", 64'(rd_a), 64'hC3C3);
  endtask

  task automatic test_pulls();
    bus_write(9'h1E0, 16'hFFFF);
    bus_write(9'h1E2, 16'h5555);
    check("R7 pull enable outputs", 64'(pen_a), 64'h7FFF);
    check("R7 pull polarity outputs", 64'(pup_a), 64'h5555);
    check("R8 pull outputs absent", 64'({pen_b, pup_b, pen_c, pup_c}), 64'd0);
    bus_read(9'h1E0);
    check("R7 pull enable read, bit 15 zero", 64'(rd_a), 64'h7FFF);
    check("R8 pull enable reads zero (36-pin)", 64'(rd_b), 64'd0);
    check("R8 pull enable reads zero (48-pin)", 64'(rd_c), 64'd0);
    bus_read(9'h1E2);
    check("R7 pull polarity read", 64'(rd_a), 64'h5555);
  endtask

  task automatic test_unmapped();
    logic [49:0] oe_snap, out_snap;
    oe_snap = oe_a; out_snap = out_a;
    bus_write(9'h008, 16'hFFFF);
    bus_write(9'h1E4, 16'hFFFF);
    check("R9 pad_oe unchanged", 64'(oe_a), 64'(oe_snap));
    check("R9 pad_out unchanged", 64'(out_a), 64'(out_snap));
    bus_read(9'h008);
    check("R9 unmapped 0x008 reads zero", 64'(rd_a), 64'd0);
    bus_read(9'h1E4);
    check("R9 unmapped 0x1E4 reads zero", 64'(rd_a), 64'd0);
  endtask

  task automatic test_read_timing();
    bus_read(9'h000);
    check("R10 read direction", 64'(rd_a), 64'hA5A5);
    pad_in = '0;
    bus_write(9'h000, 16'h1111);
    settle();
    check("R10 rdata holds without read", 64'(rd_a), 64'hA5A5);
    @(negedge clk);
    bus_addr = 9'h000; bus_wdata = 16'h2222; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R11 same-cycle read returns old", 64'(rd_a), 64'h1111);
    check("R11 write still lands", 64'(oe_a[15:0]), 64'h2222);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_direction();
    test_data();
    test_readback();
    test_upper_pins();
    test_pulls();
    test_unmapped();
    test_read_timing();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule